// File: doc/BRIEF.md
# Reciprocal-Caching Fixed-Point Divider

This block divides an unsigned 16-bit dividend by an unsigned 16-bit divisor without a divider in the result path. It multiplies the dividend by a fixed-point reciprocal of the divisor and keeps the newest divisor, with its reciprocal, in a single-entry store. A request that repeats the stored divisor pays only for a short pipelined multiply. A new divisor first runs a bit-serial restoring division of 2^32 by the divisor. The fresh reciprocal then replaces the stored one and feeds the multiply.

Requests arrive on a valid/ready handshake, and the block holds only one request at a time. Each result appears as a one-cycle valid pulse. The pulse carries the quotient, a flag that says whether the stored reciprocal was reused, and a flag that marks a zero divisor. The design suits loops that divide many values by the same number.

Top module: `recip_divider`

## Requirements
- R1: After reset, req_ready is 1 and res_valid is 0. The first request after reset is served as a miss (res_hit = 0).
- R2: For a divisor y of 2 or more, res_q equals floor(x * floor(2^32 / y) / 2^32), taken as 16 bits.
- R3: For y = 1, the reciprocal saturates to all ones and res_q equals x exactly.
- R4: For y = 0, the result comes on the first clock edge after acceptance with res_dz = 1, res_hit = 0 and res_q = 0xFFFF. The stored divisor is not altered, so a later request with the previously stored divisor still hits.
- R5: A nonzero request whose divisor equals the stored divisor is a hit (res_hit = 1). Its result pulse appears 4 rising edges after acceptance, counting the accepting edge as the first.
- R6: A nonzero request with a different divisor, or with no valid stored entry, is a miss. Its result appears 37 rising edges after acceptance, counting the accepting edge. The stored divisor becomes that divisor.
- R7: A hit leaves the stored divisor and reciprocal unchanged.
- R8: req_ready is low from the cycle after acceptance through the result cycle. res_valid lasts exactly one cycle, and req_ready is high again in the cycle after it.
- R9: For any nonzero divisor, res_dz is 0 in the result cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_x | input | 16 | Unsigned dividend |
| req_y | input | 16 | Unsigned divisor |
| res_valid | output | 1 | One-cycle result pulse |
| res_q | output | 16 | Truncated quotient |
| res_hit | output | 1 | Stored reciprocal was reused |
| res_dz | output | 1 | Divisor was zero |

## Verification
At the end of a miss, two things happen in the same cycle: the reciprocal engine writes the store, and the multiplier is launched with that same reciprocal. If the multiplier read the store instead, it would pick up the old entry. The bench provokes this case by alternating divisors, so that each miss follows a different stored divisor. It judges the result by comparing the quotient with a model built from the new divisor and by checking that the next request with that divisor hits. It also sends zero-divisor requests between repeated divisors to show that the zero path and the store do not interfere.

// File: rtl/recip_div_pkg.sv
package recip_div_pkg;
  localparam int OPW_D    = 16;  // operand width
  localparam int RCW_D    = 32;  // reciprocal fraction bits
  localparam int MULLAT_D = 3;   // multiply pipeline depth

  typedef enum logic [1:0] {ST_IDLE, ST_RECIP, ST_MUL} ctl_state_t;

  // One restoring step: shift in a zero and subtract when possible.
  function automatic logic step_take(input logic [OPW_D-1:0] rem, input logic [OPW_D-1:0] d);
    return {rem, 1'b0} >= {1'b0, d};
  endfunction
endpackage

// File: rtl/recip_engine.sv
module recip_engine #(
  parameter int OPW = recip_div_pkg::OPW_D,
  parameter int RCW = recip_div_pkg::RCW_D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] divisor,
  output logic           busy,
  output logic           done,
  output logic [RCW-1:0] recip
);
  localparam int CW = $clog2(RCW + 1);

  logic [OPW-1:0] rem, d;
  logic [CW-1:0]  cnt;
  logic [OPW:0]   shifted;
  logic           take;
  logic [OPW-1:0] rem_nx;

  // Remainder starts at 1 (the leading bit of 2^32), so y = 1 yields all ones.
  always_comb begin
    shifted = {rem, 1'b0};
    take    = shifted >= {1'b0, d};
    rem_nx  = take ? OPW'(shifted - {1'b0, d}) : shifted[OPW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      rem   <= '0;
      d     <= '0;
      recip <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        d     <= divisor;
        rem   <= OPW'(1);
        cnt   <= CW'(RCW);
        busy  <= 1'b1;
        recip <= '0;
      end else if (busy) begin
        rem   <= rem_nx;
        recip <= {recip[RCW-2:0], take};
        cnt   <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6
  engine_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
endmodule

// File: rtl/recip_cache.sv
module recip_cache #(
  parameter int OPW = recip_div_pkg::OPW_D,
  parameter int RCW = recip_div_pkg::RCW_D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [OPW-1:0] wr_tag,
  input  logic [RCW-1:0] wr_val,
  input  logic [OPW-1:0] look_tag,
  output logic           hit,
  output logic [OPW-1:0] tag,
  output logic [RCW-1:0] val
);
  logic vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= 1'b0;
      tag <= '0;
      val <= '0;
    end else if (wr_en) begin
      vld <= 1'b1;
      tag <= wr_tag;
      val <= wr_val;
    end
  end

  assign hit = vld && (tag == look_tag);

  // R1
  entry_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld) |-> $past(wr_en));
endmodule

// File: rtl/fx_mul.sv
module fx_mul #(
  parameter int OPW = recip_div_pkg::OPW_D,
  parameter int RCW = recip_div_pkg::RCW_D,
  parameter int LAT = recip_div_pkg::MULLAT_D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] a,
  input  logic [RCW-1:0] b,
  output logic           out_valid,
  output logic [OPW-1:0] q_int
);
  localparam int PW = OPW + RCW;

  logic [OPW-1:0] pipe [LAT];
  logic [LAT-1:0] vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld[0]  <= 1'b0;
      pipe[0] <= '0;
    end else begin
      vld[0]  <= in_valid;
      pipe[0] <= OPW'((PW'(a) * PW'(b)) >> RCW);
    end
  end

  for (genvar i = 1; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[i]  <= 1'b0;
        pipe[i] <= '0;
      end else begin
        vld[i]  <= vld[i-1];
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign out_valid = vld[LAT-1];
  assign q_int     = pipe[LAT-1];
endmodule

// File: rtl/recip_divider.sv
module recip_divider
  import recip_div_pkg::*;
#(
  parameter int OPW    = OPW_D,
  parameter int RCW    = RCW_D,
  parameter int MULLAT = MULLAT_D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [OPW-1:0] req_x,
  input  logic [OPW-1:0] req_y,
  output logic           res_valid,
  output logic [OPW-1:0] res_q,
  output logic           res_hit,
  output logic           res_dz
);
  ctl_state_t     st;
  logic [OPW-1:0] x_q, y_q;
  logic           hit_q;

  logic           accept, y_zero, c_hit;
  logic           eng_start, eng_busy, eng_done;
  logic [RCW-1:0] eng_recip, c_val;
  logic [OPW-1:0] c_tag;
  logic           mul_go, mul_vout;
  logic [OPW-1:0] mul_a, mul_q;
  logic [RCW-1:0] mul_b;

  assign req_ready = (st == ST_IDLE) && !res_valid;
  assign accept    = req_valid && req_ready;
  assign y_zero    = (req_y == '0);
  assign eng_start = accept && !y_zero && !c_hit;
  assign mul_go    = (accept && !y_zero && c_hit) || eng_done;
  // Fresh reciprocal goes straight to the multiplier on the write cycle.
  assign mul_a     = eng_done ? x_q : req_x;
  assign mul_b     = eng_done ? eng_recip : c_val;

  recip_engine #(.OPW(OPW), .RCW(RCW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .divisor(req_y),
    .busy(eng_busy), .done(eng_done), .recip(eng_recip));

  recip_cache #(.OPW(OPW), .RCW(RCW)) u_cache (
    .clk(clk), .rst_n(rst_n), .wr_en(eng_done), .wr_tag(y_q), .wr_val(eng_recip),
    .look_tag(req_y), .hit(c_hit), .tag(c_tag), .val(c_val));

  fx_mul #(.OPW(OPW), .RCW(RCW), .LAT(MULLAT)) u_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(mul_go), .a(mul_a), .b(mul_b),
    .out_valid(mul_vout), .q_int(mul_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      x_q       <= '0;
      y_q       <= '0;
      hit_q     <= 1'b0;
      res_valid <= 1'b0;
      res_q     <= '0;
      res_hit   <= 1'b0;
      res_dz    <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          x_q   <= req_x;
          y_q   <= req_y;
          hit_q <= c_hit;
          if (y_zero) begin
            res_valid <= 1'b1;
            res_q     <= '1;
            res_dz    <= 1'b1;
            res_hit   <= 1'b0;
          end else begin
            st <= c_hit ? ST_MUL : ST_RECIP;
          end
        end
        ST_RECIP: if (eng_done) st <= ST_MUL;
        ST_MUL: if (mul_vout) begin
          res_valid <= 1'b1;
          res_q     <= (y_q == OPW'(1)) ? x_q : mul_q;
          res_hit   <= hit_q;
          res_dz    <= 1'b0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R7
  hit_keeps_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && c_hit) |=> ($stable(c_tag) && $stable(c_val)));
  // R4
  zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && y_zero) |=> (res_valid && res_dz && !res_hit && $stable(c_tag)));
  // R6
  engine_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> (st == ST_RECIP && !eng_busy));
endmodule

// File: tb/sim_recip_divider.sv
module sim_recip_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_x = '0, req_y = '0;
  logic        res_valid;
  logic [15:0] res_q;
  logic        res_hit, res_dz;

  int n_chk = 0, n_bad = 0;
  bit  m_vld = 0;
  logic [15:0] m_tag = '0;
  bit  finished = 0;

  always #2 clk = ~clk;

  recip_divider u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_x(req_x), .req_y(req_y), .res_valid(res_valid), .res_q(res_q),
    .res_hit(res_hit), .res_dz(res_dz));

  function automatic logic [15:0] ref_q(input logic [15:0] x, input logic [15:0] y);
    logic [63:0] r;
    if (y == 0) return 16'hFFFF;
    if (y == 1) return x;
    r = 64'h1_0000_0000 / {48'd0, y};
    return 16'(({48'd0, x} * r) >> 32);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] x, input logic [15:0] y);
    bit ehit;
    int elat, lat;
    logic [15:0] eq;
    while (!req_ready) @(negedge clk);
    ehit = m_vld && (m_tag == y) && (y != 0);
    eq   = ref_q(x, y);
    elat = (y == 0) ? 1 : (ehit ? 4 : 37);
    req_x = x; req_y = y; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (!res_valid) chk(!req_ready, "R8 ready low while busy", req_ready, 0);
    while (!res_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    if (y == 0) chk(res_q == eq && res_dz, "R4 zero divisor", {res_dz, res_q}, {1'b1, eq});
    else if (y == 1) chk(res_q == eq, "R3 unity divisor", res_q, eq);
    else chk(res_q == eq, "R2 quotient", res_q, eq);
    if (y != 0) chk(!res_dz, "R9 dz low", res_dz, 0);
    if (y == 0) chk(lat == elat, "R4 latency", lat, elat);
    else if (ehit) chk(lat == elat, "R5 hit latency", lat, elat);
    else chk(lat == elat, "R6 miss latency", lat, elat);
    chk(res_hit == ehit, ehit ? "R5 hit flag" : "R6 miss flag", res_hit, ehit);
    @(negedge clk);
    chk(!res_valid && req_ready, "R8 pulse and ready", {res_valid, req_ready}, 2'b01);
    if (y != 0 && !ehit) begin m_vld = 1; m_tag = y; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] pool [6];
    pool[0] = 16'd0; pool[1] = 16'd1; pool[2] = 16'd2;
    pool[3] = 16'd3; pool[4] = 16'd7; pool[5] = 16'hFFFF;
    void'($urandom(32'd20240711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !res_valid, "R1 reset state", {req_ready, res_valid}, 2'b10);
    run(16'd1000, 16'd7);      // R1 first request misses
    run(16'd1000, 16'd7);      // R5 hit
    run(16'hFFFF, 16'd7);      // R7 entry kept, still hits
    run(16'd123, 16'd0);       // R4 zero
    run(16'd50, 16'd7);        // R4 store untouched
    run(16'hBEEF, 16'd1);      // R3 miss
    run(16'hBEEF, 16'd1);      // R3 hit
    run(16'd5, 16'hFFFF);
    run(16'hFFFF, 16'hFFFF);
    run(16'hFFFF, 16'd2);
    run(16'd9, 16'd3);         // alternating divisors stress the write/launch cycle
    run(16'd9, 16'd2);
    for (int i = 0; i < 300; i++) begin
      logic [15:0] y;
      y = ($urandom % 4 == 0) ? 16'($urandom) : pool[$urandom % 6];
      run(16'($urandom), y);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule